// File: doc/BRIEF.md
# Programmable MASH Sigma-Delta Modulator

This block is the digital fractional core of a fractional-N frequency synthesizer. It runs on the divided feedback clock. On every rising edge it issues one integer division modulus to a synchronous down-counter divider. Each modulus is the programmed integer part plus a small signed, noise-shaped offset. The offsets are chosen so that the average division ratio sits between two integers. This lets the synthesized frequency fall between integer multiples of the reference.

The offset comes from a cascade of first-order accumulators. Each carry-out is a one-bit quantizer decision, and each stage's residue feeds the next stage. A cancellation network recombines the carries so that the quantization error of the earlier stages is removed and only the last stage's error remains, high-pass shaped. The cascade runs either as two stages (second order) or as three stages (third order). The accumulator resolution is one of four widths.

Order and resolution are configuration values. They are captured only while the block is reset or cleared. The integer part and the fractional word are used live on every edge.

Top module: `mash_modulator`

## Requirements
- R1: During reset (`rst_n` low at an edge) or a synchronous clear (`clear` high at an edge), all accumulators and delay registers go to zero, and the modulus loaded at that edge is the integer part with no offset.
- R2: With a fractional value of zero after a clear, the modulus stays equal to the integer part on every edge.
- R3: With `order_sel` = 0 (second order), the offset is c1 + c2 − c2 delayed. With resolution 12 and fraction value 2048 (one half), the offsets after a clear repeat 0, +1, +1, 0.
- R4: With `order_sel` = 1 (third order), the offset adds c3 − 2·c3 delayed + c3 delayed twice. For the same half fraction, the offsets after a clear repeat 0, +2, −1, +1.
- R5: The offset always lies in −1..+2 in second order and in −3..+4 in third order.
- R6: `res_sel` codes 0, 1, 2 and 3 select widths w of 12, 16, 20 and 24 bits. The fraction value is `frac_word[23:24-w]`, and the lower 24 − w bits of `frac_word` have no effect. The accumulators wrap at 2^w.
- R7: A change of `order_sel` or `res_sel` has no effect until the next clear or reset.
- R8: Over the first 2^w moduli after a clear, the summed offsets equal the fraction value plus an end term. The end term lies in 0..+1 for second order and −1..+2 for third order, so the long-run mean equals integer + fraction / 2^w.
- R9: The modulus is registered. A new integer part shows in the modulus from the edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided feedback clock; one modulus per rising edge |
| rst_n | input | 1 | Synchronous active-low reset; also captures the configuration |
| clear | input | 1 | Synchronous clear of all state; captures the configuration |
| int_part | input | INT_W (8) | Integer part N of the division ratio; must be at least 3 |
| frac_word | input | FRAC_W (24) | Fractional word, aligned to the MSB; low bits unused below 24-bit resolution |
| order_sel | input | 1 | 0 = second order (two stages), 1 = third order (three stages) |
| res_sel | input | 2 | Resolution code: 0→12, 1→16, 2→20, 3→24 bits |
| modulus | output | INT_W+1 (9) | Division modulus for the down-counter |

## Verification
A wrong accumulator bit or wrong stage wiring changes the carry pattern at once. The short periodic sequences of a half fraction then depart from their expected values within one to four edges after a clear. A fault in a delay register or a missing cancellation term pushes the offset out of its allowed range. It can also leave a bias that shows in the summed offsets over one full wrap period, 2^w edges. A configuration register that loads outside a clear shows as a changed sequence on the first edge after the change.

// File: rtl/mash_pkg.sv
// Shared types and constants for the MASH modulator.
// Assumes four resolution codes spaced evenly from a minimum width.
package mash_pkg;

    // Cascade order encoding, matches the order_sel pin.
    typedef enum logic {
        ORD_2 = 1'b0,
        ORD_3 = 1'b1
    } order_e;

    // Configuration captured at reset or clear.
    typedef struct packed {
        order_e     order;
        logic [1:0] res;
    } cfg_t;

    localparam int RES_MIN  = 12;
    localparam int RES_STEP = 4;
    localparam int OFF_W    = 4;   // signed offset width, covers -3..+4

endpackage

// File: rtl/mash_stage.sv
// One first-order accumulator stage of the cascade.
// The accumulator is MSB-aligned in FRAC_W bits. Bits below the active
// resolution are held at zero by the mask, so the carry out of bit FRAC_W
// behaves like the carry of a w-bit accumulator that wraps at 2^w.
// Assumes din is already masked. A disabled stage holds zero and gives no carry.
module mash_stage #(
    parameter int FRAC_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic [FRAC_W-1:0] mask,
    input  logic [FRAC_W-1:0] din,
    output logic              carry,
    output logic [FRAC_W-1:0] resid
);

    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    // Add input to stored residue; split into carry and new residue.
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, din};
        carry = en & sum[FRAC_W];
        resid = en ? (sum[FRAC_W-1:0] & mask) : '0;
    end

    // Store the residue for the next edge; cleared by reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= resid;
        end
    end

    // R6
    unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q & ~mask) == '0);

    // R2
    zero_input_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && en && din == '0) |=> acc_q == $past(acc_q));

    // R1
    stage_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> acc_q == '0);

endmodule

// File: rtl/mash_cancel.sv
// Error-cancellation network. It turns the stage carries into one signed
// offset: c1 + (1-z^-1)c2, plus (1-z^-1)^2 c3 in third order.
// Assumes c3 is zero whenever second order is selected.
module mash_cancel
    import mash_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  order_e                  order,
    input  logic                    c1,
    input  logic                    c2,
    input  logic                    c3,
    output logic signed [OFF_W-1:0] offset
);

    logic c2_d, c3_d, c3_dd;
    logic signed [OFF_W-1:0] t2, t3;

    // Delay line for the carries of stages two and three.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
        end else begin
            c2_d  <= c2;
            c3_d  <= c3;
            c3_dd <= c3_d;
        end
    end

    // Combine the differenced carries into the offset.
    always_comb begin
        t2 = $signed({3'b000, c2}) - $signed({3'b000, c2_d});
        t3 = $signed({3'b000, c3}) - $signed({2'b00, c3_d, 1'b0})
           + $signed({3'b000, c3_dd});
        offset = $signed({3'b000, c1}) + t2 + ((order == ORD_3) ? t3 : '0);
    end

    // R5
    offset_range2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (order == ORD_2) |-> (offset >= -1 && offset <= 2));

    // R5
    offset_range3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (order == ORD_3) |-> (offset >= -3 && offset <= 4));

    // R3
    idle_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (order == ORD_2) |-> (!c3 && !c3_d && !c3_dd));

endmodule

// File: rtl/mash_modulator.sv
// Top of the MASH modulator. It captures the configuration on reset or
// clear, masks the fractional word to the chosen resolution, runs the
// accumulator cascade and registers integer part + offset as the modulus.
// Assumes int_part >= 3, so the modulus never goes negative.
module mash_modulator
    import mash_pkg::*;
#(
    parameter int INT_W     = 8,
    parameter int FRAC_W    = 24,
    parameter int RES_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [INT_W-1:0]     int_part,
    input  logic [FRAC_W-1:0]    frac_word,
    input  logic                 order_sel,
    input  logic [RES_SEL_W-1:0] res_sel,
    output logic [INT_W:0]       modulus
);

    localparam int NSTAGE = 3;
    localparam int OUT_W  = INT_W + 1;

    cfg_t                    cfg_q;
    logic [FRAC_W-1:0]       res_mask;
    logic [FRAC_W-1:0]       chain [0:NSTAGE];
    logic [NSTAGE-1:0]       carries;
    logic signed [OFF_W-1:0] offset;
    logic [OUT_W-1:0]        off_ext;

    // Configuration register: loads only during reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cfg_q.order <= order_e'(order_sel);
            cfg_q.res   <= res_sel;
        end
    end

    // MSB-aligned mask that keeps the top RES_MIN + RES_STEP*res bits.
    always_comb begin
        res_mask = {FRAC_W{1'b1}} << (FRAC_W - (RES_MIN + RES_STEP * int'(cfg_q.res)));
    end

    assign chain[0] = frac_word & res_mask;

    // Accumulator cascade; the third stage runs only in third order.
    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        logic stage_en;
        assign stage_en = (k < 2) ? 1'b1 : (cfg_q.order == ORD_3);
        mash_stage #(.FRAC_W(FRAC_W)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clear),
            .en    (stage_en),
            .mask  (res_mask),
            .din   (chain[k]),
            .carry (carries[k]),
            .resid (chain[k+1])
        );
    end

    mash_cancel u_cancel (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear),
        .order  (cfg_q.order),
        .c1     (carries[0]),
        .c2     (carries[1]),
        .c3     (carries[2]),
        .offset (offset)
    );

    // Sign-extend the offset to the output width for modular addition.
    assign off_ext = {{(OUT_W-OFF_W){offset[OFF_W-1]}}, offset};

    // Output register: the integer part alone on clear, otherwise plus offset.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            modulus <= {1'b0, int_part};
        end else begin
            modulus <= {1'b0, int_part} + off_ext;
        end
    end

    // R1
    clear_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> modulus == {1'b0, $past(int_part)});

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> $stable(cfg_q));

    // R9
    output_near_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !$past(clear)) |-> ($signed({1'b0, modulus}) - $signed({2'b00, $past(int_part)}) >= -3
                    && $signed({1'b0, modulus}) - $signed({2'b00, $past(int_part)}) <= 4));

endmodule

// File: tb/mash_modulator_test.sv
// Directed bench for mash_modulator: one task per scenario.
module mash_modulator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic [7:0]  int_part = 8'd10;
    logic [23:0] frac_word = '0;
    logic        order_sel = 1'b0;
    logic [1:0]  res_sel = 2'd0;
    logic [8:0]  modulus;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    mash_modulator uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .int_part(int_part),
        .frac_word(frac_word), .order_sel(order_sel), .res_sel(res_sel),
        .modulus(modulus)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pulse clear with the given configuration; the modulus must equal int_part.
    task automatic do_clear(input logic ord, input logic [1:0] res);
        @(negedge clk);
        order_sel = ord; res_sel = res; clear = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clear = 1'b0;
        check("R1 clear", int'(modulus), int'(int_part));
    endtask

    // Advance one edge and compare the offset.
    task automatic step_expect(input string req, input int exp_off);
        @(posedge clk);
        @(negedge clk);
        check(req, int'(modulus) - int'(int_part), exp_off);
    endtask

    task automatic t_reset;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R1 reset", int'(modulus), 10);
        rst_n = 1'b1;
    endtask

    // R2 and R9: zero fraction, then a new integer part one edge later.
    task automatic t_zero_frac;
        frac_word = 24'h0;
        do_clear(1'b1, 2'd0);
        for (int i = 0; i < 6; i++) step_expect("R2 zero fraction", 0);
        int_part = 8'd20;
        @(posedge clk); @(negedge clk);
        check("R9 integer update", int'(modulus), 20);
        step_expect("R2 zero fraction", 0);
        int_part = 8'd10;
        @(posedge clk); @(negedge clk);
    endtask

    // R3, R4: half fraction at 12 bits in both orders.
    task automatic t_half_patterns;
        int p2[4] = '{0, 1, 1, 0};
        int p3[4] = '{0, 2, -1, 1};
        frac_word = 24'h800000;
        do_clear(1'b0, 2'd0);
        for (int i = 0; i < 8; i++) step_expect("R3 second order", p2[i%4]);
        do_clear(1'b1, 2'd0);
        for (int i = 0; i < 8; i++) step_expect("R4 third order", p3[i%4]);
    endtask

    // R6: each width, with junk below the active bits.
    task automatic t_resolution;
        int p2[4] = '{0, 1, 1, 0};
        logic [23:0] words[4] = '{24'h800ABC, 24'h8000C3, 24'h80000F, 24'h800000};
        for (int r = 0; r < 4; r++) begin
            frac_word = words[r];
            do_clear(1'b0, 2'(r));
            for (int i = 0; i < 8; i++) step_expect("R6 resolution", p2[i%4]);
        end
        // 0x000FFF at 12 bits is zero: low bits must do nothing.
        frac_word = 24'h000FFF;
        do_clear(1'b1, 2'd0);
        for (int i = 0; i < 6; i++) step_expect("R6 low bits ignored", 0);
    endtask

    // R7: configuration pins change mid-run without a clear.
    task automatic t_config_hold;
        int p2[4] = '{0, 1, 1, 0};
        int p3[4] = '{0, 2, -1, 1};
        frac_word = 24'h800000;
        do_clear(1'b0, 2'd0);
        for (int i = 0; i < 4; i++) step_expect("R7 before change", p2[i]);
        order_sel = 1'b1; res_sel = 2'd3;
        for (int i = 0; i < 8; i++) step_expect("R7 change ignored", p2[i%4]);
        do_clear(1'b1, 2'd0);
        for (int i = 0; i < 4; i++) step_expect("R7 after clear", p3[i]);
    endtask

    // R5, R8: full wrap period, range and summed offset.
    task automatic t_average(input logic ord, input logic [1:0] res, input logic [23:0] word);
        int w, nper, fval, total, off, lo, hi, elo, ehi;
        logic range_ok;
        w = 12 + 4 * int'(res);
        nper = 1 << w;
        fval = int'(word >> (24 - w));
        lo = ord ? -3 : -1;  hi = ord ? 4 : 2;
        elo = ord ? -1 : 0;  ehi = ord ? 2 : 1;
        frac_word = word;
        do_clear(ord, res);
        total = 0; range_ok = 1'b1;
        for (int i = 0; i < nper; i++) begin
            @(posedge clk); @(negedge clk);
            off = int'(modulus) - int'(int_part);
            total += off;
            if ((off < lo || off > hi) && range_ok) begin
                range_ok = 1'b0;
                check("R5 offset range", off, (off < lo) ? lo : hi);
            end
        end
        if (range_ok) check("R5 offset range", 1, 1);
        if (total - fval < elo || total - fval > ehi)
            check("R8 mean", total, fval);
        else
            check("R8 mean", 1, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_zero_frac();
        t_half_patterns();
        t_resolution();
        t_config_hold();
        t_average(1'b0, 2'd0, 24'h5A3000);
        t_average(1'b1, 2'd0, 24'h5A3000);
        t_average(1'b1, 2'd1, 24'h3C71D5);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule